// File: doc/BRIEF.md
# Dual-Channel Converter Link Sequencer

This block sits on the host side of a three-wire serial link to a dual 12-bit digital-to-analog converter. It takes one request, which carries a code for channel A, a code for channel B, a speed-mode bit, a power-down bit, a channel select and a flag that asks for both outputs to change together. It turns that request into 16-bit frames, each sent most significant bit first with an active-low select, a serial clock that idles high and a data line. All link timing is counted in system clocks and set by parameters.

When both outputs must change together, the block sends two frames. The first places the channel B code in the converter's holding register only. The second loads channel A and, through the converter's own transfer, moves the held code into channel B at the same moment. Both frames reuse the speed mode that the last single-channel write recorded, so the converter never sees a mode change between the two halves of the update. A single-channel write sends one frame and records the mode it carries. A busy output is high while a request is in progress. A one-cycle done pulse closes each request.

Top module: `dacseq_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, cs_n = 1, sclk = 1, sdo = 0, busy = 0 and done = 0.
- R2: sclk is high in every cycle in which cs_n is high. cs_n rises only in a cycle in which sclk is high and was also high in the cycle before.
- R3: In every frame, cs_n is low for exactly SETUP_CYC cycles before the first falling sclk edge. Each low phase of sclk lasts exactly LO_CYC cycles. Each high phase lasts exactly HI_CYC cycles, and that includes the high phase between the last rising edge and the rise of cs_n. Exactly 16 falling sclk edges occur while cs_n is low.
- R4: The frame bit that sdo carries at the k-th falling edge is bit 16-k, so the most significant bit goes first. sdo does not change in any cycle in which sclk is low.
- R5: The frame layout is fixed. Bit 15 = 1 selects a channel A load. Bit 14 is the speed mode (1 = fast). Bit 13 is power-down. Bit 12 = 1 marks a holding-register-only write. Bits 11..0 carry the code.
- R6: A request with req_sync = 1 sends exactly two frames. The first is code B with bit 15 = 0 and bit 12 = 1. The second is code A with bit 15 = 1 and bit 12 = 0.
- R7: A single-channel request puts req_fast in bit 14 and records it as the current mode. Both frames of a req_sync request carry the recorded mode in bit 14 and ignore req_fast. After reset the recorded mode is 0.
- R8: A request with req_sync = 0 sends exactly one frame. With req_chan_b = 0 the frame is code A with bit 15 = 1 and bit 12 = 0. With req_chan_b = 1 it is code B with bit 15 = 0 and bit 12 = 0.
- R9: Bit 13 of every frame of a request equals that request's req_pdown.
- R10: busy is high from the cycle after a request is accepted until the cycle of done. done is a one-cycle pulse with busy low. It appears GAP_CYC cycles after cs_n rises at the end of the last frame. Between the two frames of a req_sync request, cs_n stays high for at least GAP_CYC cycles.
- R11: A request presented while busy is high is dropped. It sends no frame, and neither then nor later does it change the recorded mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_code_a | input | 12 | Code for channel A |
| req_code_b | input | 12 | Code for channel B |
| req_fast | input | 1 | Speed mode for a single-channel write |
| req_sync | input | 1 | 1 = update both channels together |
| req_chan_b | input | 1 | Single-channel target: 0 = A, 1 = B |
| req_pdown | input | 1 | Power-down bit for every frame of the request |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Link select, active low |
| sclk | output | 1 | Link clock, idles high |
| sdo | output | 1 | Link data, most significant bit first |

## Verification
The assertions check the link waveform on every cycle. They cover the clock idling high under a high select, the rise of select only after a full clock-high phase, exact setup, low and high phase widths, data held steady while the clock is low, and a single-cycle done pulse while not busy. Only the bench scenarios can show frame contents and order. It decodes every frame from the pins and compares it with words built from the request fields and a model of the recorded speed mode, so it shows which code goes first in a paired update, that the mode carries over, how bit 13 follows, and that a request made while busy sends nothing.

// File: rtl/dacseq_pkg.sv
// Shared constants and types for the converter link sequencer.
// Assumes a fixed 16-bit frame with four control bits above the code.
package dacseq_pkg;
    localparam int FRAME_W   = 16;
    localparam int CTRL_W    = 4;
    localparam int CODE_W    = FRAME_W - CTRL_W;
    // control bit positions decoded by the converter
    localparam int POS_SEL_A = 15;
    localparam int POS_FAST  = 14;
    localparam int POS_PDN   = 13;
    localparam int POS_HOLD  = 12;

    typedef enum logic [1:0] {
        FK_LATCH_A   = 2'd0,
        FK_LATCH_B   = 2'd1,
        FK_HOLD_ONLY = 2'd2
    } frame_kind_e;

    typedef logic [CODE_W-1:0]  code_t;
    typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/dacseq_frame.sv
// Frame builder: packs a frame kind, code, speed mode and power-down bit
// into the 16-bit word. Purely combinational; assumes inputs held stable
// by the controller while the link loads the word.
module dacseq_frame
    import dacseq_pkg::*;
(
    input  frame_kind_e kind,
    input  code_t       code,
    input  logic        fast,
    input  logic        pdown,
    output frame_t      word
);

    // assemble control field and code
    always_comb begin
        word                = '0;
        word[CODE_W-1:0]    = code;
        word[POS_FAST]      = fast;
        word[POS_PDN]       = pdown;
        case (kind)
            FK_LATCH_A:   word[POS_SEL_A] = 1'b1;
            FK_HOLD_ONLY: word[POS_HOLD]  = 1'b1;
            default:      ;
        endcase
    end

endmodule

// File: rtl/dacseq_link.sv
// Serial link engine: shifts one frame out MSB first with an active-low
// select and a clock that idles high. Phase lengths are exact counts of
// system clocks. Assumes start is only pulsed while the engine is idle;
// a start seen in any other state is ignored.
module dacseq_link
    import dacseq_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int LO_CYC    = 3,
    parameter int HI_CYC    = 3,
    parameter int GAP_CYC   = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  frame_t word,
    output logic   cs_n,
    output logic   sclk,
    output logic   sdo,
    output logic   frame_done
);

    localparam int M1    = (SETUP_CYC > LO_CYC) ? SETUP_CYC : LO_CYC;
    localparam int M2    = (HI_CYC > GAP_CYC) ? HI_CYC : GAP_CYC;
    localparam int MAXC  = (M1 > M2) ? M1 : M2;
    localparam int CNT_W = $clog2(MAXC) + 1;
    localparam int BIT_W = $clog2(FRAME_W);

    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LO_LD    = CNT_W'(LO_CYC - 1);
    localparam logic [CNT_W-1:0] HI_LD    = CNT_W'(HI_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_W - 1);

    typedef enum logic [2:0] {
        L_IDLE, L_SETUP, L_LOW, L_HIGH, L_GAP
    } lstate_e;

    lstate_e          state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bitc;
    frame_t           shreg;
    logic             cs_q;
    logic             sclk_q;

    // phase sequencer, phase counter, bit counter and shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= L_IDLE;
            cnt    <= '0;
            bitc   <= '0;
            shreg  <= '0;
            cs_q   <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            case (state)
                L_IDLE: begin
                    if (start) begin
                        state <= L_SETUP;
                        cnt   <= SETUP_LD;
                        cs_q  <= 1'b0;
                        shreg <= word;
                        bitc  <= '0;
                    end
                end
                L_SETUP: begin
                    if (cnt == '0) begin
                        state  <= L_LOW;
                        cnt    <= LO_LD;
                        sclk_q <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                L_LOW: begin
                    if (cnt == '0) begin
                        state  <= L_HIGH;
                        cnt    <= HI_LD;
                        sclk_q <= 1'b1;
                        if (bitc != LAST_BIT) begin
                            shreg <= {shreg[FRAME_W-2:0], 1'b0};
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                L_HIGH: begin
                    if (cnt == '0) begin
                        if (bitc == LAST_BIT) begin
                            state <= L_GAP;
                            cnt   <= GAP_LD;
                            cs_q  <= 1'b1;
                            shreg <= '0;
                        end else begin
                            state  <= L_LOW;
                            cnt    <= LO_LD;
                            sclk_q <= 1'b0;
                            bitc   <= bitc + 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                L_GAP: begin
                    if (cnt == '0) begin
                        state <= L_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= L_IDLE;
            endcase
        end
    end

    // drive pins and end-of-frame indication
    always_comb begin
        cs_n       = cs_q;
        sclk       = sclk_q;
        sdo        = shreg[FRAME_W-1];
        frame_done = (state == L_GAP) && (cnt == '0);
    end

endmodule

// File: rtl/dacseq_ctrl.sv
// Request controller: accepts a request when idle, decides on one or two
// frames, chooses kind, code and speed mode for each, and pulses done
// after the last frame's gap. Keeps the mode of the last single-channel
// write so that both frames of a paired update repeat it.
module dacseq_ctrl
    import dacseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  code_t       req_code_a,
    input  code_t       req_code_b,
    input  logic        req_fast,
    input  logic        req_sync,
    input  logic        req_chan_b,
    input  logic        req_pdown,
    input  logic        frame_done,
    output logic        start,
    output frame_kind_e kind,
    output code_t       code,
    output logic        fast,
    output logic        pdown,
    output logic        busy,
    output logic        done
);

    typedef enum logic [1:0] {C_IDLE, C_FIRST, C_LAST} cstate_e;

    cstate_e     state;
    code_t       code_a_q;
    code_t       code_q;
    frame_kind_e kind_q;
    logic        start_q;
    logic        fast_q;
    logic        pdn_q;
    logic        mode_q;
    logic        done_q;

    // request acceptance, frame sequencing and mode bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= C_IDLE;
            code_a_q <= '0;
            code_q   <= '0;
            kind_q   <= FK_LATCH_A;
            start_q  <= 1'b0;
            fast_q   <= 1'b0;
            pdn_q    <= 1'b0;
            mode_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            case (state)
                C_IDLE: begin
                    if (req_valid) begin
                        start_q  <= 1'b1;
                        pdn_q    <= req_pdown;
                        code_a_q <= req_code_a;
                        if (req_sync) begin
                            state  <= C_FIRST;
                            kind_q <= FK_HOLD_ONLY;
                            code_q <= req_code_b;
                            fast_q <= mode_q;
                        end else begin
                            state  <= C_LAST;
                            fast_q <= req_fast;
                            mode_q <= req_fast;
                            if (req_chan_b) begin
                                kind_q <= FK_LATCH_B;
                                code_q <= req_code_b;
                            end else begin
                                kind_q <= FK_LATCH_A;
                                code_q <= req_code_a;
                            end
                        end
                    end
                end
                C_FIRST: begin
                    if (frame_done) begin
                        state   <= C_LAST;
                        start_q <= 1'b1;
                        kind_q  <= FK_LATCH_A;
                        code_q  <= code_a_q;
                    end
                end
                C_LAST: begin
                    if (frame_done) begin
                        state  <= C_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= C_IDLE;
            endcase
        end
    end

    // outputs toward the frame builder, link and host
    always_comb begin
        start = start_q;
        kind  = kind_q;
        code  = code_q;
        fast  = fast_q;
        pdown = pdn_q;
        busy  = (state != C_IDLE);
        done  = done_q;
    end

endmodule

// File: rtl/dacseq_top.sv
// Top of the converter link sequencer: request controller, frame builder
// and serial link engine. Timing parameters are in system clocks and must
// each be at least 1.
module dacseq_top
    import dacseq_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int LO_CYC    = 3,
    parameter int HI_CYC    = 3,
    parameter int GAP_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code_a,
    input  logic [CODE_W-1:0] req_code_b,
    input  logic              req_fast,
    input  logic              req_sync,
    input  logic              req_chan_b,
    input  logic              req_pdown,
    output logic              busy,
    output logic              done,
    output logic              cs_n,
    output logic              sclk,
    output logic              sdo
);

    logic        start;
    logic        frame_done;
    frame_kind_e kind;
    code_t       code;
    logic        fast;
    logic        pdown;
    frame_t      word;

    dacseq_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_code_a (req_code_a),
        .req_code_b (req_code_b),
        .req_fast   (req_fast),
        .req_sync   (req_sync),
        .req_chan_b (req_chan_b),
        .req_pdown  (req_pdown),
        .frame_done (frame_done),
        .start      (start),
        .kind       (kind),
        .code       (code),
        .fast       (fast),
        .pdown      (pdown),
        .busy       (busy),
        .done       (done)
    );

    dacseq_frame frame_i (
        .kind  (kind),
        .code  (code),
        .fast  (fast),
        .pdown (pdown),
        .word  (word)
    );

    dacseq_link #(
        .SETUP_CYC (SETUP_CYC),
        .LO_CYC    (LO_CYC),
        .HI_CYC    (HI_CYC),
        .GAP_CYC   (GAP_CYC)
    ) link_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word       (word),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdo        (sdo),
        .frame_done (frame_done)
    );

endmodule

// File: rtl/dacseq_chk.sv
// Link waveform checker bound to dacseq_top. Measures clock and select
// run lengths with saturating counters and checks them against the
// timing parameters; also checks data stability and the done pulse.
module dacseq_chk #(
    parameter int SETUP_CYC = 2,
    parameter int LO_CYC    = 3,
    parameter int HI_CYC    = 3,
    parameter int GAP_CYC   = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sclk,
    input logic sdo,
    input logic busy,
    input logic done
);

    localparam logic [15:0] SETUP_W = 16'(SETUP_CYC);
    localparam logic [15:0] LO_W    = 16'(LO_CYC);
    localparam logic [15:0] HI_W    = 16'(HI_CYC);

    logic        prev_sclk;
    logic        prev_cs;
    logic        first_q;
    logic [15:0] run_q;
    logic [15:0] cs_run_q;

    // run-length counters for clock and select levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_sclk <= 1'b1;
            prev_cs   <= 1'b1;
            first_q   <= 1'b1;
            run_q     <= '0;
            cs_run_q  <= '0;
        end else begin
            prev_sclk <= sclk;
            prev_cs   <= cs_n;
            run_q     <= (sclk != prev_sclk) ? 16'd1 :
                         ((run_q == 16'hFFFF) ? run_q : run_q + 16'd1);
            cs_run_q  <= (cs_n != prev_cs) ? 16'd1 :
                         ((cs_run_q == 16'hFFFF) ? cs_run_q : cs_run_q + 16'd1);
            first_q   <= cs_n ? 1'b1 : ((prev_sclk && !sclk) ? 1'b0 : first_q);
        end
    end

    // R2
    sclk_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    // R2
    cs_rise_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (sclk && $past(sclk)));

    // R3
    low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!prev_sclk && sclk && !cs_n) |-> (run_q == LO_W));

    // R3
    high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_sclk && !sclk && !first_q) |-> (run_q == HI_W));

    // R3
    setup_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_sclk && !sclk && first_q) |-> (cs_run_q == SETUP_W));

    // R4
    sdo_stable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk |-> $stable(sdo));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind dacseq_top dacseq_chk #(
    .SETUP_CYC (SETUP_CYC),
    .LO_CYC    (LO_CYC),
    .HI_CYC    (HI_CYC),
    .GAP_CYC   (GAP_CYC)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .sdo   (sdo),
    .busy  (busy),
    .done  (done)
);

// File: tb/dacseq_top_tb.sv
// Bench: sweeps request kinds, modes, power-down and code patterns; decodes
// frames from the pins and compares with words built from the requirements.
module dacseq_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int T_SETUP    = 3;
    localparam int T_LO       = 2;
    localparam int T_HI       = 4;
    localparam int T_GAP      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_code_a = '0;
    logic [11:0] req_code_b = '0;
    logic        req_fast = 1'b0;
    logic        req_sync = 1'b0;
    logic        req_chan_b = 1'b0;
    logic        req_pdown = 1'b0;
    logic        busy, done, cs_n, sclk, sdo;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    bit mode_m = 0;

    // monitor state
    logic [15:0] hist [0:511];
    int          bits_hist [0:511];
    int tot_cap = 0, tot_done = 0;
    int err_lo = 0, err_hi = 0, err_setup = 0, err_gap = 0, err_done = 0;
    int err_sdo = 0, err_idle = 0, err_rise = 0, err_tail = 0;
    int lenS = 0, lenC = 0, bitc = 0, fr_in_busy = 0;
    logic [15:0] shw = '0;
    logic m_sclk = 1'b1, m_cs = 1'b1, m_sdo = 1'b0;
    bit first_f = 0;

    dacseq_top #(
        .SETUP_CYC (T_SETUP),
        .LO_CYC    (T_LO),
        .HI_CYC    (T_HI),
        .GAP_CYC   (T_GAP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_code_a(req_code_a), .req_code_b(req_code_b),
        .req_fast(req_fast), .req_sync(req_sync), .req_chan_b(req_chan_b),
        .req_pdown(req_pdown), .busy(busy), .done(done),
        .cs_n(cs_n), .sclk(sclk), .sdo(sdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // pin monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && !sclk) err_idle++;
            if (!sclk && sdo !== m_sdo) err_sdo++;
            if (!busy) fr_in_busy = 0;
            if (cs_n != m_cs) begin
                if (!cs_n) begin
                    if (fr_in_busy > 0 && lenC < T_GAP) err_gap++;
                    first_f = 1; bitc = 0; shw = '0;
                end else begin
                    if (!sclk) err_rise++;
                    if (lenS != T_HI) err_tail++;
                    if (tot_cap < 512) begin
                        hist[tot_cap] = shw;
                        bits_hist[tot_cap] = bitc;
                    end
                    tot_cap++;
                    fr_in_busy++;
                end
            end
            if (sclk != m_sclk && !cs_n) begin
                if (sclk) begin
                    if (lenS != T_LO) err_lo++;
                end else begin
                    if (first_f) begin
                        if (lenC != T_SETUP) err_setup++;
                        first_f = 0;
                    end else if (lenS != T_HI) err_hi++;
                    shw = {shw[14:0], sdo};
                    bitc++;
                end
            end
            if (done) begin
                tot_done++;
                if (lenC != T_GAP) err_done++;
            end
            lenS = (sclk != m_sclk) ? 1 : lenS + 1;
            lenC = (cs_n != m_cs) ? 1 : lenC + 1;
        end
        m_sclk = sclk; m_cs = cs_n; m_sdo = sdo;
    end

    task automatic check(bit ok, string tag, string what, int act, int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    function automatic logic [11:0] pat(int k);
        case (k)
            0: return 12'h000;
            1: return 12'hFFF;
            2: return 12'h800;
            3: return 12'h001;
            4: return 12'h555;
            default: return 12'hA3C;
        endcase
    endfunction

    task automatic do_req(bit s, bit chb, bit f, bit pd,
                          logic [11:0] a, logic [11:0] b, bit inject);
        int base, dbase, n, expn;
        logic [15:0] w0, w1;
        bit em;
        @(negedge clk);
        while (busy) @(negedge clk);
        #1;
        base = tot_cap; dbase = tot_done;
        req_sync = s; req_chan_b = chb; req_fast = f; req_pdown = pd;
        req_code_a = a; req_code_b = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R10", "busy after accept", int'(busy), 1);
        if (inject) begin
            repeat (10) @(negedge clk);
            req_sync = 1'b0; req_chan_b = ~chb; req_fast = ~f;
            req_code_a = ~a; req_code_b = ~b; req_pdown = ~pd; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        #1;
        n = tot_cap - base;
        expn = s ? 2 : 1;
        em = s ? mode_m : f;
        if (s) begin
            w0 = {1'b0, em, pd, 1'b1, b};
            w1 = {1'b1, em, pd, 1'b0, a};
        end else if (chb) begin
            w0 = {1'b0, em, pd, 1'b0, b};
            w1 = '0;
        end else begin
            w0 = {1'b1, em, pd, 1'b0, a};
            w1 = '0;
        end
        check(n == expn, s ? "R6" : "R8", "frame count", n, expn);
        check(tot_done - dbase == 1, "R10", "done pulses", tot_done - dbase, 1);
        if (n == expn) begin
            check(bits_hist[base] == 16, "R3", "falling edges", bits_hist[base], 16);
            check(hist[base][11:0] == (s ? b : (chb ? b : a)), "R5", "code field",
                  int'(hist[base][11:0]), int'(s ? b : (chb ? b : a)));
            check(hist[base][14] == em, "R7", "mode bit", int'(hist[base][14]), int'(em));
            check(hist[base][13] == pd, "R9", "power-down bit", int'(hist[base][13]), int'(pd));
            check(hist[base] == w0, s ? "R6" : "R8", "first frame", int'(hist[base]), int'(w0));
            if (s) begin
                check(bits_hist[base+1] == 16, "R3", "falling edges", bits_hist[base+1], 16);
                check(hist[base+1] == w1, "R6", "second frame", int'(hist[base+1]), int'(w1));
                check(hist[base+1][14] == em, "R7", "mode bit 2nd", int'(hist[base+1][14]), int'(em));
            end
        end
        if (!s) mode_m = f;
        if (inject) begin
            repeat (40) @(negedge clk);
            #1;
            check(tot_cap == base + n, "R11", "frames after dropped request", tot_cap - base, n);
            check(!busy, "R11", "busy after dropped request", int'(busy), 0);
        end
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R10 watchdog: actual busy=%0b expected 0", busy);
            summary();
            $finish;
        end
    end

    // main sequence
    initial begin
        repeat (4) @(negedge clk);
        check({cs_n, sclk, sdo, busy, done} == 5'b11000, "R1", "pins in reset",
              int'({cs_n, sclk, sdo, busy, done}), 5'b11000);
        rst_n = 1'b1;
        @(negedge clk);
        check({cs_n, sclk, sdo, busy, done} == 5'b11000, "R1", "pins after reset",
              int'({cs_n, sclk, sdo, busy, done}), 5'b11000);

        // paired update straight after reset uses the reset mode (R7)
        do_req(1'b1, 1'b0, 1'b1, 1'b0, 12'h123, 12'hFED, 1'b0);

        for (int f = 0; f < 2; f++)
            for (int pd = 0; pd < 2; pd++)
                for (int cb = 0; cb < 2; cb++)
                    for (int s = 0; s < 2; s++)
                        for (int k = 0; k < 6; k++)
                            do_req(s[0], cb[0], s[0] ? ~f[0] : f[0], pd[0],
                                   pat(k), pat((k + 3) % 6), 1'b0);

        // requests while busy are dropped (R11)
        do_req(1'b1, 1'b0, 1'b0, 1'b0, 12'h0F0, 12'h70E, 1'b1);
        do_req(1'b0, 1'b1, 1'b0, 1'b1, 12'h3C3, 12'h999, 1'b1);
        do_req(1'b1, 1'b1, 1'b1, 1'b0, 12'h111, 12'hEEE, 1'b0);

        check(err_idle == 0 && err_rise == 0, "R2", "clock high under select",
              err_idle + err_rise, 0);
        check(err_setup == 0, "R3", "setup width errors", err_setup, 0);
        check(err_lo == 0, "R3", "low width errors", err_lo, 0);
        check(err_hi == 0 && err_tail == 0, "R3", "high width errors", err_hi + err_tail, 0);
        check(err_sdo == 0, "R4", "data change while clock low", err_sdo, 0);
        check(err_gap == 0, "R10", "gap between paired frames", err_gap, 0);
        check(err_done == 0, "R10", "done lag after select rise", err_done, 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule